// File: doc/BRIEF.md
# Posit Quire Dot-Product Accumulator

This block keeps a 128-bit two's-complement fixed-point accumulator, the quire, and uses it to form exact sums of products of 8-bit posits. Operands use the 8-bit posit format with two exponent bits. Each product is decoded, multiplied, aligned onto a grid whose unit is 2^-48 and added with no rounding. The only rounding happens when the sum is read out as an 8-bit posit.

Software or a sequencer uses it in a fixed pattern. A clear command zeroes the quire. Any number of multiply-accumulate commands follow, one per accepted handshake. A read command then rounds the sum once and returns it on a result port that pulses valid for a single cycle. If either operand of a product is not-a-real (NaR), the quire takes its own NaR pattern and keeps it until the next clear.

Top module: `posit_quire_mac`

## Requirements
- R1: During reset `cmdReady` and `resValid` are low. After reset the quire holds zero, so a read returns 0x00.
- R2: A command is accepted on a rising edge where `cmdValid` and `cmdReady` are both high. `cmdReady` is high in every cycle after the first cycle out of reset. `cmdOp` encodes 0 = clear, 1 = multiply-accumulate, 2 = read. Code 3 is accepted and has no effect on the quire or on the result port.
- R3: A clear sets the quire to zero. This also ends a NaR state.
- R4: A multiply-accumulate adds the exact product of `opA` and `opB` to the quire. The operands are 8-bit posits with two exponent bits: sign in bit 7, and negative values are the two's complement of the whole word. The quire is an integer in units of 2^-48, so no product is rounded.
- R5: When the product is negative it is subtracted from the quire, so equal and opposite products cancel exactly.
- R6: If either operand is zero (0x00) and neither is NaR, the quire is unchanged.
- R7: If either operand is NaR (0x80), the quire becomes NaR (only bit 127 set). It stays NaR through later multiply-accumulates and reads until a clear, and while it is NaR a read returns 0x80.
- R8: A read rounds the quire to the nearest 8-bit posit. A tie goes to the even bit pattern.
- R9: A read saturates. Magnitudes above the largest posit return 0x7F (0x81 when negative). A nonzero magnitude below the smallest posit returns 0x01 (0xFF when negative). A nonzero, non-NaR sum never reads as 0x00 or 0x80.
- R10: After an accepted read, `resValid` is high for exactly the next cycle and `resData` holds the rounded value. The read leaves the quire unchanged. `resValid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | A command is offered |
| cmdReady | output | 1 | The block accepts a command this cycle |
| cmdOp | input | 2 | Command code: clear, multiply-accumulate, read, no-op |
| opA | input | 8 | First posit operand |
| opB | input | 8 | Second posit operand |
| resValid | output | 1 | One-cycle strobe marking a read result |
| resData | output | 8 | Rounded posit read from the quire |

## Verification
A multiply-accumulate or clear takes effect on the quire at the same edge that accepts it, so a read issued in the very next cycle already sees it. A read result appears on `resData` with `resValid` high during the cycle after the accepting edge. The bench drives commands back to back at falling edges and samples the result port at the next falling edge. At the falling edge after every non-read command it also checks that `resValid` is low, which covers the one-cycle width of the strobe.

// File: rtl/posit_quire_pkg.sv
package posit_quire_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_MAC   = 2'd1,
    OP_READ  = 2'd2,
    OP_NOP   = 2'd3
  } quire_op_t;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic clear;
    logic mac;
    logic read;
  } quire_stb_t;

endpackage

// File: rtl/posit_decode.sv
// Unpacks one posit word into sign, binary scale and significand.
module posit_decode #(
  parameter int N   = 8,
  parameter int ES  = 2,
  parameter int SCW = 9
) (
  input  logic [N-1:0]          word,
  output logic                  isZero,
  output logic                  isNar,
  output logic                  sign,
  output logic signed [SCW-1:0] scale,
  output logic [N-3-ES:0]       sig
);
  localparam int MW = N - 1;
  localparam int FW = N - 3 - ES;
  localparam int KW = $clog2(N) + 1;

  logic [MW-1:0]         mag;
  logic [MW-1:0]         tail;
  logic                  runBit;
  logic                  runDone;
  logic [KW-1:0]         runLen;
  logic [ES-1:0]         expBits;
  logic [FW-1:0]         fracBits;
  logic signed [SCW-1:0] runS;
  logic signed [SCW-1:0] regimeVal;

  always_comb begin
    sign   = word[N-1];
    isZero = (word == '0);
    isNar  = (word == {1'b1, {MW{1'b0}}});
    mag    = sign ? MW'(~word + 1'b1) : word[MW-1:0];

    // length of the leading run of identical bits
    runBit  = mag[MW-1];
    runLen  = '0;
    runDone = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (!runDone && mag[i] == runBit) runLen = runLen + KW'(1);
      else runDone = 1'b1;
    end

    // drop run and terminator; missing bits read as zero
    tail = mag << (runLen + KW'(1));
    {expBits, fracBits} = (ES + FW)'(tail >> (MW - ES - FW));

    runS      = SCW'(runLen);
    regimeVal = runBit ? (runS - SCW'(1)) : -runS;
    scale     = (regimeVal <<< ES) + $signed({{(SCW - ES){1'b0}}, expBits});
    sig       = {1'b1, fracBits};
  end
endmodule

// File: rtl/posit_round.sv
// Rounds a quire to the nearest posit, ties to even, with saturation.
module posit_round #(
  parameter int N   = 8,
  parameter int ES  = 2,
  parameter int QW  = 128,
  parameter int SCW = 9
) (
  input  logic [QW-1:0] quire,
  output logic [N-1:0]  result
);
  localparam int MAXS = (N - 2) << ES;
  localparam int UW   = 2 * MAXS;
  localparam int CW   = ES + QW - 2 + N;
  localparam logic signed [SCW-1:0] HI_S = SCW'(MAXS);
  localparam logic signed [SCW-1:0] LO_S = -HI_S;

  logic                  neg;
  logic                  isZero;
  logic                  isNar;
  logic [QW-2:0]         magL;
  logic [SCW-1:0]        lead;
  logic signed [SCW-1:0] sRaw;
  logic signed [SCW-1:0] sClamp;
  logic signed [SCW-1:0] regimeVal;
  logic [QW-3:0]         fracRaw;
  logic [QW-3:0]         fracUse;
  logic [ES-1:0]         expBits;
  logic [SCW-1:0]        runAmt;
  logic [SCW-1:0]        regLen;
  logic [CW-1:0]         regVec;
  logic [CW-1:0]         tailVec;
  logic [CW-1:0]         combo;
  logic [N-2:0]          body;
  logic                  rndBit;
  logic                  sticky;
  logic                  roundUp;
  logic [N-1:0]          bumped;
  logic [N-1:0]          posWord;

  always_comb begin
    neg    = quire[QW-1];
    isZero = (quire == '0);
    isNar  = (quire == {1'b1, {(QW-1){1'b0}}});
    magL   = neg ? (QW-1)'(~quire + 1'b1) : quire[QW-2:0];

    lead = '0;
    for (int i = 0; i < QW - 1; i++) begin
      if (magL[i]) lead = SCW'(i);
    end
    fracRaw = (QW-2)'(magL << (SCW'(QW - 2) - lead));
    sRaw    = $signed(lead) - SCW'(UW);

    // clamp to the posit range; clamped values carry no fraction
    if (sRaw > HI_S) begin
      sClamp  = HI_S;
      fracUse = '0;
    end else if (sRaw < LO_S) begin
      sClamp  = LO_S;
      fracUse = '0;
    end else begin
      sClamp  = sRaw;
      fracUse = fracRaw;
    end

    regimeVal = sClamp >>> ES;
    expBits   = sClamp[ES-1:0];
    if (!regimeVal[SCW-1]) begin
      runAmt = regimeVal;
      regVec = ~({CW{1'b1}} >> (runAmt + SCW'(1)));
      regLen = runAmt + SCW'(2);
    end else begin
      runAmt = -regimeVal;
      regVec = {1'b1, {(CW-1){1'b0}}} >> runAmt;
      regLen = runAmt + SCW'(1);
    end

    tailVec = {expBits, fracUse, {N{1'b0}}};
    combo   = regVec | (tailVec >> regLen);
    body    = combo[CW-1 -: N-1];
    rndBit  = combo[CW-N];
    sticky  = |combo[CW-N-1:0];
    roundUp = rndBit & (sticky | body[0]);
    bumped  = {1'b0, body} + {{(N-1){1'b0}}, roundUp};
    posWord = bumped[N-1] ? {1'b0, body} : bumped;

    if (isNar)       result = {1'b1, {(N-1){1'b0}}};
    else if (isZero) result = '0;
    else if (neg)    result = ~posWord + 1'b1;
    else             result = posWord;
  end
endmodule

// File: rtl/quire_ctrl.sv
// Handshake and command decode; drives the strobe struct.
module quire_ctrl
  import posit_quire_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       cmdReady,
  output quire_stb_t stb,
  output logic       resValid
);
  logic fire;

  always_comb begin
    fire      = cmdValid & cmdReady;
    stb.clear = fire && (cmdOp == OP_CLEAR);
    stb.mac   = fire && (cmdOp == OP_MAC);
    stb.read  = fire && (cmdOp == OP_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReady <= 1'b0;
      resValid <= 1'b0;
    end else begin
      cmdReady <= 1'b1;
      resValid <= stb.read;
    end
  end

  // R10
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stb.read |=> resValid);

  // R10
  pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(stb.read));

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmdReady |=> cmdReady);
endmodule

// File: rtl/quire_datapath.sv
// Quire register, product alignment and read-out register.
module quire_datapath
  import posit_quire_pkg::*;
#(
  parameter int N   = 8,
  parameter int ES  = 2,
  parameter int QW  = 128,
  parameter int SCW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  quire_stb_t    stb,
  input  logic [N-1:0]  opA,
  input  logic [N-1:0]  opB,
  output logic [N-1:0]  resData
);
  localparam int SW   = N - 2 - ES;
  localparam int PW   = 2 * SW;
  localparam int DROP = 2 * (SW - 1);
  localparam int SHW  = QW + DROP;
  localparam int UW   = 2 * ((N - 2) << ES);
  localparam logic [QW-1:0] QNAR = {1'b1, {(QW-1){1'b0}}};
  localparam logic [N-1:0]  PNAR = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0]          ops      [2];
  logic                  decZero  [2];
  logic                  decNar   [2];
  logic                  decSign  [2];
  logic signed [SCW-1:0] decScale [2];
  logic [SW-1:0]         decSig   [2];

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    posit_decode #(.N(N), .ES(ES), .SCW(SCW)) u_dec (
      .word   (ops[g]),
      .isZero (decZero[g]),
      .isNar  (decNar[g]),
      .sign   (decSign[g]),
      .scale  (decScale[g]),
      .sig    (decSig[g])
    );
  end

  logic [QW-1:0]         quire;
  logic                  quireIsNar;
  logic [PW-1:0]         prodSig;
  logic signed [SCW-1:0] shiftS;
  logic [SCW-1:0]        shiftU;
  logic [SHW-1:0]        wide;
  logic [QW-1:0]         addMag;
  logic [QW-1:0]         addend;
  logic                  anyNar;
  logic                  anyZero;
  logic [N-1:0]          rounded;

  always_comb begin
    prodSig = PW'(decSig[0]) * PW'(decSig[1]);
    shiftS  = decScale[0] + decScale[1] + SCW'(UW);
    shiftU  = shiftS;
    wide    = SHW'(prodSig) << shiftU;
    addMag  = QW'(wide >> DROP);
    addend  = (decSign[0] ^ decSign[1]) ? (~addMag + 1'b1) : addMag;
    anyNar  = decNar[0] | decNar[1];
    anyZero = decZero[0] | decZero[1];
    quireIsNar = (quire == QNAR);
  end

  posit_round #(.N(N), .ES(ES), .QW(QW), .SCW(SCW)) u_round (
    .quire  (quire),
    .result (rounded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quire <= '0;
    end else if (stb.clear) begin
      quire <= '0;
    end else if (stb.mac) begin
      if (anyNar || quireIsNar) quire <= QNAR;
      else if (!anyZero)        quire <= quire + addend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           resData <= '0;
    else if (stb.read) resData <= rounded;
  end

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stb.clear |=> (quire == '0));

  // R7
  nar_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (quireIsNar && !stb.clear) |=> quireIsNar);

  // R7
  nar_read_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.read && quireIsNar) |=> (resData == PNAR));

  // R6
  zero_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.mac && anyZero && !anyNar) |=> $stable(quire));

  // R10
  read_keep_chk: assert property (@(posedge clk) disable iff (rst)
    stb.read |=> $stable(quire));

  // R9
  no_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.read && quire != '0 && !quireIsNar) |=> (resData != '0 && resData != PNAR));
endmodule

// File: rtl/posit_quire_mac.sv
// Top: control and datapath joined by the strobe struct.
module posit_quire_mac
  import posit_quire_pkg::*;
#(
  parameter int PN  = 8,
  parameter int PES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic [1:0]    cmdOp,
  input  logic [PN-1:0] opA,
  input  logic [PN-1:0] opB,
  output logic          resValid,
  output logic [PN-1:0] resData
);
  localparam int QW  = 16 * PN;
  localparam int SCW = $clog2(QW) + 2;

  quire_stb_t stb;

  quire_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdReady (cmdReady),
    .stb      (stb),
    .resValid (resValid)
  );

  quire_datapath #(.N(PN), .ES(PES), .QW(QW), .SCW(SCW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .resData (resData)
  );
endmodule

// File: tb/posit_quire_mac_test.sv
module posit_quire_mac_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic       cmdReady;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic       resValid;
  logic [7:0] resData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [127:0] mq = '0;
  bit           mNar = 1'b0;

  always #4 clk = ~clk;

  posit_quire_mac uut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .opA(opA), .opB(opB), .resValid(resValid), .resData(resData)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // magnitude of an n-bit posit (n <= 9, es = 2) in units of 2^-48
  function automatic logic [127:0] posMag(input logic [8:0] w, input int n);
    logic [8:0]   m;
    logic [127:0] v;
    logic         rb;
    int i, k, e, fb, r, s;
    m = w[n-1] ? (9'd0 - w) : w;
    m = m & 9'((1 << n) - 1);
    i = n - 2;
    rb = m[i];
    k = 0;
    while (i >= 0 && m[i] == rb) begin k++; i--; end
    i--;
    e = 0;
    for (int j = 0; j < 2; j++) begin
      e = e * 2 + ((i >= 0) ? int'(m[i]) : 0);
      i--;
    end
    fb = (i + 1 > 0) ? i + 1 : 0;
    r = rb ? k - 1 : -k;
    s = 4 * r + e;
    v = (128'(1) << fb) | 128'(m & 9'((1 << fb) - 1));
    return v << (s - fb + 48);
  endfunction

  function automatic logic [7:0] roundMag(input logic [127:0] mg);
    logic [127:0] lo, hi, mid;
    if (mg >= posMag(9'h07F, 8)) return 8'h7F;
    if (mg <= posMag(9'h001, 8)) return 8'h01;
    for (int p = 1; p < 127; p++) begin
      lo = posMag(9'(p), 8);
      hi = posMag(9'(p + 1), 8);
      if (mg >= lo && mg < hi) begin
        if (mg == lo) return 8'(p);
        mid = posMag(9'(2 * p + 1), 9);
        if (mg < mid) return 8'(p);
        if (mg > mid) return 8'(p + 1);
        return (p % 2 == 0) ? 8'(p) : 8'(p + 1);
      end
    end
    return 8'h7F;
  endfunction

  function automatic logic [7:0] expRead();
    logic [7:0] p;
    if (mNar) return 8'h80;
    if (mq == '0) return 8'h00;
    if (mq[127]) begin
      p = roundMag(128'd0 - mq);
      return 8'd0 - p;
    end
    return roundMag(mq);
  endfunction

  function automatic void modelMac(input logic [7:0] a, input logic [7:0] b);
    logic [127:0] prod;
    if (a == 8'h80 || b == 8'h80) mNar = 1'b1;
    else if (!mNar && a != 8'h00 && b != 8'h00) begin
      prod = (posMag({1'b0, a}, 8) >> 24) * (posMag({1'b0, b}, 8) >> 24);
      if (a[7] ^ b[7]) mq = mq - prod;
      else mq = mq + prod;
    end
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic doCmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                       input string tag);
    logic [7:0] e;
    cmdValid = 1'b1; cmdOp = op; opA = a; opB = b;
    @(negedge clk);
    cmdValid = 1'b0;
    if (op == 2'd0) begin mq = '0; mNar = 1'b0; end
    else if (op == 2'd1) modelMac(a, b);
    if (op == 2'd2) begin
      e = expRead();
      check(resValid == 1'b1, {tag, " R10 resValid"}, 128'(resValid), 128'(1));
      check(resData == e, tag, 128'(resData), 128'(e));
    end else begin
      check(resValid == 1'b0, "R10 no strobe", 128'(resValid), 128'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    logic [7:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmdReady == 1'b0, "R1 ready in reset", 128'(cmdReady), 128'(0));
    check(resValid == 1'b0, "R1 valid in reset", 128'(resValid), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(cmdReady == 1'b1, "R2 ready after reset", 128'(cmdReady), 128'(1));
    doCmd(2'd2, 8'h00, 8'h00, "R1 read after reset");

    // R4 exact products, R8 tie cases
    doCmd(2'd1, 8'h40, 8'h40, "R4");
    doCmd(2'd2, 8'h00, 8'h00, "R4 one");
    check(resData == 8'h40, "R4 one direct", 128'(resData), 128'h40);
    doCmd(2'd1, 8'h20, 8'h40, "R8");
    doCmd(2'd2, 8'h00, 8'h00, "R8 tie down to even");
    check(resData == 8'h40, "R8 tie 1.0625", 128'(resData), 128'h40);
    doCmd(2'd1, 8'h20, 8'h40, "R8");
    doCmd(2'd1, 8'h20, 8'h40, "R8");
    doCmd(2'd2, 8'h00, 8'h00, "R8 tie up to even");
    check(resData == 8'h42, "R8 tie 1.1875", 128'(resData), 128'h42);
    // R10 second read sees unchanged quire
    doCmd(2'd2, 8'h00, 8'h00, "R10 repeat read");

    // R4 exactness through large cancelling terms
    doCmd(2'd0, 8'h00, 8'h00, "R3");
    doCmd(2'd1, 8'h40, 8'h40, "R4");
    doCmd(2'd1, 8'h7F, 8'h7F, "R4");
    doCmd(2'd1, 8'h81, 8'h7F, "R5");
    doCmd(2'd2, 8'h00, 8'h00, "R4 survives cancel");
    doCmd(2'd1, 8'hC0, 8'h40, "R5");
    doCmd(2'd2, 8'h00, 8'h00, "R5 exact zero");
    check(resData == 8'h00, "R5 cancel to zero", 128'(resData), 128'h00);

    // R9 saturation
    doCmd(2'd1, 8'h7F, 8'h7F, "R9");
    doCmd(2'd1, 8'h7F, 8'h7F, "R9");
    doCmd(2'd2, 8'h00, 8'h00, "R9 high");
    check(resData == 8'h7F, "R9 maxpos", 128'(resData), 128'h7F);
    doCmd(2'd0, 8'h00, 8'h00, "R3");
    doCmd(2'd1, 8'h81, 8'h7F, "R9");
    doCmd(2'd2, 8'h00, 8'h00, "R9 negative high");
    doCmd(2'd0, 8'h00, 8'h00, "R3");
    doCmd(2'd1, 8'h01, 8'h01, "R9");
    doCmd(2'd2, 8'h00, 8'h00, "R9 low");
    check(resData == 8'h01, "R9 minpos", 128'(resData), 128'h01);
    doCmd(2'd0, 8'h00, 8'h00, "R3");
    doCmd(2'd1, 8'hFF, 8'h01, "R9");
    doCmd(2'd2, 8'h00, 8'h00, "R9 negative low");
    check(resData == 8'hFF, "R9 neg minpos", 128'(resData), 128'hFF);

    // R6 zero operand, R2 no-op code
    doCmd(2'd0, 8'h00, 8'h00, "R3");
    doCmd(2'd1, 8'h48, 8'h40, "R4");
    doCmd(2'd1, 8'h00, 8'h7F, "R6");
    doCmd(2'd1, 8'h7F, 8'h00, "R6");
    doCmd(2'd2, 8'h00, 8'h00, "R6 unchanged");
    doCmd(2'd3, 8'h7F, 8'h7F, "R2");
    doCmd(2'd2, 8'h00, 8'h00, "R2 no-op ignored");

    // R7 NaR sticky, R3 clear releases it
    doCmd(2'd1, 8'h80, 8'h40, "R7");
    doCmd(2'd2, 8'h00, 8'h00, "R7 nar");
    check(resData == 8'h80, "R7 nar direct", 128'(resData), 128'h80);
    doCmd(2'd1, 8'h40, 8'h40, "R7");
    doCmd(2'd1, 8'h00, 8'h40, "R7");
    doCmd(2'd2, 8'h00, 8'h00, "R7 still nar");
    doCmd(2'd0, 8'h00, 8'h00, "R3");
    doCmd(2'd2, 8'h00, 8'h00, "R3 clear ends nar");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      r = $urandom % 32;
      a = 8'($urandom);
      b = 8'($urandom);
      if (r == 0) doCmd(2'd0, a, b, "R3");
      else if (r < 6) doCmd(2'd2, a, b, "R8 random read");
      else if (r == 6) doCmd(2'd3, a, b, "R2");
      else if (r < 12) doCmd(2'd1, {a[7], 2'b10, a[4:0]}, b, "R4");
      else doCmd(2'd1, a, b, "R4");
    end
    doCmd(2'd2, 8'h00, 8'h00, "R8 final read");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule